// File: doc/BRIEF.md
# Timer Trigger Event Controller

This block sits in front of one channel of a multi-channel general-purpose timer and decides when an outside event should start or clear that channel's counter. A 5-bit select code picks one event from the available sources. These are eight external trigger pins, a comparator output, a clock-monitor safety event, eight trigger outputs from simple 16-bit timers and eight trigger outputs from sibling channels. The chosen signal is synchronised, and its rising edge becomes a one-cycle event.

The event is turned into a one-cycle clear pulse when the counter is running, or a one-cycle start pulse when it is stopped. The legality of the select code depends on the operating mode. The clear can be masked while the channel's positive output is high. The start can be held off until software has read the counter, and it is always blocked after an emergency stop. The counter, waveform generation, capture logic and register file live elsewhere and use these two pulses.

Top module: `trig_event_ctrl`

## Requirements
- R1: Select codes 00000 to 00111 pick external trigger pins 0 to 7 in every mode.
- R2: Code 01000 picks the comparator output and code 01100 picks the clock-monitor event. Every other code with the two upper bits equal to 01 yields no event.
- R3: In the modes other than CAPTURE, codes 10000 to 10111 pick 16-bit timer triggers 0 to 7 and codes 11000 to 11111 pick sibling channel triggers 0 to 7. Mode is encoded as 00 TIMER, 01 CAPTURE, 10 PWM1 and 11 PWM2.
- R4: In CAPTURE mode (mode 01), any code with bit 4 set yields no event.
- R5: Code 11000 plus the channel index CH_ID (a self-selection) never yields an event.
- R6: One rising edge of the selected source gives exactly one event. The event gives a clear pulse if `running` is high, and otherwise a start pulse, never both. The pulse is one cycle wide and rises on the third clock edge after the source rises.
- R7: In modes other than CAPTURE, with `clr_mask_en` high, an event gives no clear while `pos_out` is high. With `clr_mask_en` low, the clear is always given.
- R8: In CAPTURE mode, `clr_mask_en` has no effect on the clear.
- R9: With `start_gate` high, a stopped counter gets a start only if `cnt_rd` has pulsed since the last start pulse. With `start_gate` low, no read is needed.
- R10: While `estop` is high, no start pulse is given, whatever `start_gate` is.
- R11: During and after reset both outputs are low and no read is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 5 | Trigger source select code |
| mode | input | 2 | 00 TIMER, 01 CAPTURE, 10 PWM1, 11 PWM2 |
| clr_mask_en | input | 1 | Mask the clear while the positive output is high |
| start_gate | input | 1 | Require a counter read before each start |
| pos_out | input | 1 | Level of the channel's positive-phase output |
| running | input | 1 | Counter is counting |
| estop | input | 1 | Counter is halted by an emergency stop |
| cnt_rd | input | 1 | One-cycle strobe for a read of the counter register |
| ext_trg | input | 8 | External trigger pins |
| cmp_out | input | 1 | Comparator output |
| clk_mon | input | 1 | Clock-monitor safety event |
| tmr_trg | input | 8 | 16-bit timer trigger outputs |
| ch_trg | input | 8 | Sibling channel trigger outputs |
| start_p | output | 1 | One-cycle counter start pulse |
| clear_p | output | 1 | One-cycle counter clear pulse |

## Verification
The source selection is exercised by raising one source per select code. The codes include external pins, the comparator, the clock monitor, a 16-bit timer and a sibling channel, plus reserved codes, the self code and bit-4 codes in CAPTURE mode. Comparing a pulse against no pulse shows whether the decoder honours the mode and legality rules. Each legal code is tried with `running` both low and high, which shows whether an event is routed to start or to clear. The same edge is then repeated with the clear mask on and `pos_out` toggled in TIMER and in CAPTURE, with the start gate on before and after a counter read, and with `estop` high. These runs separate the masking, gating and blocking paths from one another.

// File: rtl/trig_event_ctrl.sv
module trig_event_ctrl #(
  parameter int unsigned CH_ID = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] sel,
  input  logic [1:0] mode,
  input  logic       clr_mask_en,
  input  logic       start_gate,
  input  logic       pos_out,
  input  logic       running,
  input  logic       estop,
  input  logic       cnt_rd,
  input  logic [7:0] ext_trg,
  input  logic       cmp_out,
  input  logic       clk_mon,
  input  logic [7:0] tmr_trg,
  input  logic [7:0] ch_trg,
  output logic       start_p,
  output logic       clear_p
);

  localparam logic [2:0] SELF_IDX = 3'(CH_ID);
  localparam logic [1:0] MODE_CAP = 2'b01;

  logic       is_cap;
  logic       src_raw, src_ok;
  logic [2:0] sync_q;
  logic       evt, clr_req, start_req, armed;

  assign is_cap = (mode == MODE_CAP);

  always_comb begin
    src_raw = 1'b0;
    src_ok  = 1'b0;
    case (sel[4:3])
      2'b00: begin
        src_raw = ext_trg[sel[2:0]];
        src_ok  = 1'b1;
      end
      2'b01: begin
        if (sel[2:0] == 3'b000) begin
          src_raw = cmp_out;
          src_ok  = 1'b1;
        end else if (sel[2:0] == 3'b100) begin
          src_raw = clk_mon;
          src_ok  = 1'b1;
        end
      end
      2'b10: begin
        src_raw = tmr_trg[sel[2:0]];
        src_ok  = !is_cap;
      end
      default: begin
        src_raw = ch_trg[sel[2:0]];
        src_ok  = !is_cap && (sel[2:0] != SELF_IDX);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], src_raw & src_ok};
  end

  assign evt       = sync_q[1] & ~sync_q[2];
  assign clr_req   = evt & running & ~(clr_mask_en & pos_out & ~is_cap);
  assign start_req = evt & ~running & ~estop & (~start_gate | armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_p <= 1'b0;
      clear_p <= 1'b0;
      armed   <= 1'b0;
    end else begin
      start_p <= start_req;
      clear_p <= clr_req;
      if (start_req)   armed <= 1'b0;
      else if (cnt_rd) armed <= 1'b1;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) start_p |=> !start_p); // R6
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) clear_p |=> !clear_p); // R6
  AST_START_CLEAR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(start_p && clear_p)); // R6
  AST_NO_START_ESTOP: assert property (@(posedge clk) disable iff (!rst_n) start_p |-> !$past(estop)); // R10
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n) (start_p && $past(start_gate)) |-> $past(armed)); // R9
  AST_CLR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    clear_p |-> !($past(clr_mask_en) && $past(pos_out) && ($past(mode) != MODE_CAP))); // R7

endmodule

// File: tb/trig_event_ctrl_tb.sv
`timescale 1ns/1ps
module trig_event_ctrl_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [4:0] sel = '0;
  logic [1:0] mode = 2'b00;
  logic       clr_mask_en = 1'b0, start_gate = 1'b0, pos_out = 1'b0;
  logic       running = 1'b0, estop = 1'b0, cnt_rd = 1'b0;
  logic [7:0] ext_trg = '0, tmr_trg = '0, ch_trg = '0;
  logic       cmp_out = 1'b0, clk_mon = 1'b0;
  logic       start_p, clear_p;

  trig_event_ctrl #(.CH_ID(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .mode(mode), .clr_mask_en(clr_mask_en),
    .start_gate(start_gate), .pos_out(pos_out), .running(running), .estop(estop),
    .cnt_rd(cnt_rd), .ext_trg(ext_trg), .cmp_out(cmp_out), .clk_mon(clk_mon),
    .tmr_trg(tmr_trg), .ch_trg(ch_trg), .start_p(start_p), .clear_p(clear_p)
  );

  int n_run = 0, n_fail = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_src(input logic [4:0] code, input logic v);
    case (code[4:3])
      2'b00:   ext_trg[code[2:0]] = v;
      2'b01:   begin cmp_out = v; clk_mon = v; end
      2'b10:   tmr_trg[code[2:0]] = v;
      default: ch_trg[code[2:0]] = v;
    endcase
  endtask

  // driver: expected {start,clear} pushed before the source edge
  task automatic trig(input logic [4:0] code, input bit s, input bit c, input string req);
    sel = code;
    @(negedge clk);
    if (s || c) begin
      exp_q.push_back({s, c});
      tag_q.push_back(req);
    end
    drive_src(code, 1'b1);
    repeat (10) @(negedge clk);
    drive_src(code, 1'b0);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, {req, " pending"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  // monitor: pops on every produced pulse
  always @(negedge clk) begin
    if (rst_n && !done && (start_p || clear_p)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected pulse", {start_p, clear_p}, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({start_p, clear_p} == e, t, {start_p, clear_p}, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(start_p == 1'b0 && clear_p == 1'b0, "R11 reset outputs", {start_p, clear_p}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: no read remembered after reset
    start_gate = 1'b1;
    trig(5'b00000, 0, 0, "R11 gate no read after reset");
    start_gate = 1'b0;

    // R6 latency: pulse on third edge after the source rises
    sel = 5'b00000;
    @(negedge clk);
    exp_q.push_back(2'b10);
    tag_q.push_back("R6 latency");
    ext_trg[0] = 1'b1;
    @(negedge clk); chk(start_p == 1'b0, "R6 early 1", start_p, 0);
    @(negedge clk); chk(start_p == 1'b0, "R6 early 2", start_p, 0);
    @(negedge clk); chk(start_p == 1'b1, "R6 on time", start_p, 1);
    @(negedge clk); chk(start_p == 1'b0, "R6 width", start_p, 0);
    repeat (10) @(negedge clk);
    ext_trg[0] = 1'b0;
    repeat (4) @(negedge clk);

    trig(5'b00011, 1, 0, "R1 ext3 start");
    trig(5'b00111, 1, 0, "R1 ext7 start");
    running = 1'b1;
    trig(5'b00101, 0, 1, "R1 R6 ext5 clear while running");
    running = 1'b0;

    trig(5'b01000, 1, 0, "R2 comparator");
    trig(5'b01100, 1, 0, "R2 clock monitor");
    trig(5'b01001, 0, 0, "R2 reserved 01001");
    trig(5'b01101, 0, 0, "R2 reserved 01101");
    trig(5'b01011, 0, 0, "R2 reserved 01011");

    running = 1'b1;
    trig(5'b10101, 0, 1, "R3 timer5 TIMER");
    mode = 2'b10;
    trig(5'b11100, 0, 1, "R3 channel4 PWM1");
    trig(5'b11010, 0, 0, "R5 self select");
    mode = 2'b11;
    running = 1'b0;
    trig(5'b10000, 1, 0, "R3 timer0 PWM2 start");

    mode = 2'b01;
    trig(5'b10011, 0, 0, "R4 capture timer code");
    trig(5'b11001, 0, 0, "R4 capture channel code");
    running = 1'b1;
    trig(5'b00001, 0, 1, "R4 capture ext1 clear");

    clr_mask_en = 1'b1; pos_out = 1'b1;
    trig(5'b00001, 0, 1, "R8 capture ignores mask");
    mode = 2'b00;
    trig(5'b00001, 0, 0, "R7 masked clear");
    pos_out = 1'b0;
    trig(5'b00001, 0, 1, "R7 mask with low output");
    clr_mask_en = 1'b0; pos_out = 1'b1;
    trig(5'b00001, 0, 1, "R7 mask off high output");
    pos_out = 1'b0;
    running = 1'b0;

    start_gate = 1'b1;
    trig(5'b00010, 0, 0, "R9 gated no read");
    cnt_rd = 1'b1; @(negedge clk); cnt_rd = 1'b0;
    trig(5'b00010, 1, 0, "R9 gated after read");
    trig(5'b00010, 0, 0, "R9 read consumed");
    start_gate = 1'b0;

    estop = 1'b1;
    trig(5'b00100, 0, 0, "R10 estop blocks start");
    start_gate = 1'b1;
    cnt_rd = 1'b1; @(negedge clk); cnt_rd = 1'b0;
    trig(5'b00100, 0, 0, "R10 estop blocks armed start");
    estop = 1'b0;
    trig(5'b00100, 1, 0, "R9 R10 start after estop release");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule